// File: doc/BRIEF.md
# Buffered Byte-Wide Slave Port

This block lets an external bus master move bytes into and out of the chip over an 8-bit parallel bus. The master controls the bus with three asynchronous lines: a chip select, a read strobe and a write strobe. Each line has its own polarity bit. The local side sees two 32-bit words. The inbound word collects bytes the master writes. The outbound word supplies bytes the master reads. Each word is split into four byte lanes. Lane k sits at bits 8k+7 down to 8k.

In buffered mode (`cfg_mode` equal to 2'b11) the block keeps two independent lane pointers, one for writes and one for reads. Each pointer steps through lanes 0, 1, 2, 3 and back to 0. In any other mode the port acts as a single-byte latch on lane 0. The master's strobes pass through a two-flop synchroniser. A small state machine per strobe then finds each completed transfer, so the local clock can run unrelated to the master.

Each strobe machine has two states, `ST_IDLE` and `ST_HELD`, and three transitions:
- grab: from `ST_IDLE` to `ST_HELD`, when chip select and the strobe are both active.
- finish: from `ST_HELD` to `ST_IDLE`, when the strobe drops while chip select is still active. This emits a one-cycle done.
- abort: from `ST_HELD` to `ST_IDLE`, when chip select drops first. No done is emitted.

The port also goes to `ST_IDLE` whenever it is disabled. The local side clears per-lane status bits by reading the inbound word or writing the outbound word. It receives an interrupt pulse and a sticky flag.

Top module: `bpsp_port`

## Requirements
- R1: After reset, and while `cfg_enable` is 0, the port holds both pointers at lane 0, `in_full` at 4'b0000, `out_empty` at 4'b1111, `irq_pulse` low and `ext_doe` low.
- R2: Each of chip select, read strobe and write strobe is active high when its polarity bit is 1 and active low when its polarity bit is 0.
- R3: In buffered mode, successive completed master writes store the bus byte into inbound lanes 0, 1, 2, 3. Lane k is bits 8k+7:8k of `host_in_word`. After lane 3 the next write goes to lane 0 again.
- R4: In buffered mode, `ext_dout` presents the outbound lane at the read pointer. The read pointer moves to the next lane when a read completes, and wraps from 3 to 0.
- R5: A transfer completes only on the trailing edge of its strobe while chip select is active. A strobe with chip select inactive changes no data, status or pointer.
- R6: `ext_doe` is high only while the port is enabled and the chip select and read strobe pins are both at their active levels.
- R7: When `cfg_mode` is not 2'b11, every write lands in lane 0 and every read returns lane 0. Each completed transfer counts as an interrupt event.
- R8: A completed write sets `in_full` for its lane, and a `host_in_rd` cycle clears all `in_full` bits. If both happen in the same cycle, the lane being written stays set.
- R9: `out_empty` bits start at 1. A local `host_out_wr` clears them all, and a completed master read sets the bit of the lane read.
- R10: When `cfg_irq_en` is 1, `irq_pulse` is high for one cycle after a buffered write or read wraps past lane 3. `irq_flag` then stays high until `irq_clr`. When `cfg_irq_en` is 0, no pulse is produced.
- R11: Dropping `cfg_enable` while the port is active returns both pointers to lane 0 and restores the R1 status values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_cs | input | 1 | Master chip select pin |
| ext_rd | input | 1 | Master read strobe pin |
| ext_wr | input | 1 | Master write strobe pin |
| ext_din | input | 8 | Bus byte from the master |
| ext_dout | output | 8 | Bus byte to the master |
| ext_doe | output | 1 | Output enable for the bus drivers |
| cfg_enable | input | 1 | Port on; 0 stops it and resets its state |
| cfg_mode | input | 2 | 2'b11 selects buffered mode, any other value selects single-byte mode |
| cfg_cs_pol | input | 1 | Chip select polarity, 1 means active high |
| cfg_rd_pol | input | 1 | Read strobe polarity, 1 means active high |
| cfg_wr_pol | input | 1 | Write strobe polarity, 1 means active high |
| cfg_irq_en | input | 1 | Interrupt enable |
| host_in_rd | input | 1 | Local read of the inbound word, clears `in_full` |
| host_in_word | output | 32 | Inbound word, four byte lanes |
| in_full | output | 4 | Per-lane fresh-data bits for inbound lanes |
| host_out_wr | input | 1 | Local write of the outbound word |
| host_out_wdata | input | 32 | Outbound word written by the local side |
| out_empty | output | 4 | Per-lane consumed bits for outbound lanes |
| irq_pulse | output | 1 | One-cycle interrupt event |
| irq_flag | output | 1 | Sticky interrupt flag |
| irq_clr | input | 1 | Clears `irq_flag` |

## Verification
The collision of interest is a master write that completes in the same local cycle as a local read of the inbound word. In that cycle the write sets one `in_full` bit and the read clears all of them. The bench counts the register stages from the strobe pin to the done cycle, releases the write strobe, and raises `host_in_rd` exactly in that done cycle. It then expects the lane just written to remain marked full and to hold the new byte. Random byte streams with a fixed seed, checked against a bench model of lanes and pointers, cover the ordinary sequencing around that directed case.

// File: rtl/bpsp_pkg.sv
package bpsp_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HELD = 1'b1
    } strobe_state_t;

    localparam logic [1:0] MODE_BUFFERED = 2'b11;
endpackage

// File: rtl/bpsp_sync.sv
module bpsp_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/bpsp_strobe_fsm.sv
module bpsp_strobe_fsm
    import bpsp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic cs_act,
    input  logic stb_act,
    output logic done
);
    strobe_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: grab, finish, abort
    always_comb begin
        state_d = state_q;
        if (!run) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (cs_act && stb_act) state_d = ST_HELD;
                ST_HELD: if (!cs_act || !stb_act) state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: done = 1'b0;
            ST_HELD: done = run && cs_act && !stb_act;
            default: done = 1'b0;
        endcase
    end

    // R5
    trailing_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(stb_act) && $past(cs_act));
endmodule

// File: rtl/bpsp_port.sv
module bpsp_port
    import bpsp_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int WORD_W     = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_cs,
    input  logic              ext_rd,
    input  logic              ext_wr,
    input  logic [BYTE_W-1:0] ext_din,
    output logic [BYTE_W-1:0] ext_dout,
    output logic              ext_doe,
    input  logic              cfg_enable,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_cs_pol,
    input  logic              cfg_rd_pol,
    input  logic              cfg_wr_pol,
    input  logic              cfg_irq_en,
    input  logic              host_in_rd,
    output logic [WORD_W-1:0] host_in_word,
    output logic [LANES-1:0]  in_full,
    input  logic              host_out_wr,
    input  logic [WORD_W-1:0] host_out_wdata,
    output logic [LANES-1:0]  out_empty,
    output logic              irq_pulse,
    output logic              irq_flag,
    input  logic              irq_clr
);
    localparam int PTR_W  = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int SYNC_W = BYTE_W + 3;
    localparam logic [PTR_W-1:0] LAST_LANE = PTR_W'(LANES - 1);

    // polarity correction at the pins (R2)
    logic cs_pin_act, rd_pin_act, wr_pin_act;
    assign cs_pin_act = cfg_cs_pol ? ext_cs : ~ext_cs;
    assign rd_pin_act = cfg_rd_pol ? ext_rd : ~ext_rd;
    assign wr_pin_act = cfg_wr_pol ? ext_wr : ~ext_wr;

    logic [SYNC_W-1:0] sync_q;
    logic [BYTE_W-1:0] din_s;
    logic cs_s, rd_s, wr_s;

    bpsp_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ext_din, cs_pin_act, rd_pin_act, wr_pin_act}),
        .q     (sync_q)
    );
    assign {din_s, cs_s, rd_s, wr_s} = sync_q;

    logic wr_done, rd_done;

    bpsp_strobe_fsm u_wr_fsm (
        .clk(clk), .rst_n(rst_n), .run(cfg_enable),
        .cs_act(cs_s), .stb_act(wr_s), .done(wr_done)
    );
    bpsp_strobe_fsm u_rd_fsm (
        .clk(clk), .rst_n(rst_n), .run(cfg_enable),
        .cs_act(cs_s), .stb_act(rd_s), .done(rd_done)
    );

    logic buffered;
    assign buffered = (cfg_mode == MODE_BUFFERED);

    // byte captured while the write strobe is still active
    logic [BYTE_W-1:0] wr_hold_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              wr_hold_q <= '0;
        else if (cs_s && wr_s)   wr_hold_q <= din_s;
    end

    // lane pointers (R3, R4, R7, R11)
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else if (!cfg_enable || !buffered) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            if (wr_done) wr_ptr_q <= (wr_ptr_q == LAST_LANE) ? '0 : wr_ptr_q + PTR_W'(1);
            if (rd_done) rd_ptr_q <= (rd_ptr_q == LAST_LANE) ? '0 : rd_ptr_q + PTR_W'(1);
        end
    end

    logic [BYTE_W-1:0] in_lane  [LANES];
    logic [BYTE_W-1:0] out_lane [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic wr_hit, rd_hit;
        assign wr_hit = wr_done && (wr_ptr_q == PTR_W'(g));
        assign rd_hit = rd_done && (rd_ptr_q == PTR_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      in_lane[g] <= '0;
            else if (wr_hit) in_lane[g] <= wr_hold_q;
        end

        // R8: master-side set wins over local clear
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           in_full[g] <= 1'b0;
            else if (!cfg_enable) in_full[g] <= 1'b0;
            else if (wr_hit)      in_full[g] <= 1'b1;
            else if (host_in_rd)  in_full[g] <= 1'b0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           out_lane[g] <= '0;
            else if (host_out_wr) out_lane[g] <= host_out_wdata[g*BYTE_W +: BYTE_W];
        end

        // R9
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           out_empty[g] <= 1'b1;
            else if (!cfg_enable) out_empty[g] <= 1'b1;
            else if (rd_hit)      out_empty[g] <= 1'b1;
            else if (host_out_wr) out_empty[g] <= 1'b0;
        end

        assign host_in_word[g*BYTE_W +: BYTE_W] = in_lane[g];
    end

    // bus drive (R4, R6)
    assign ext_dout = out_lane[rd_ptr_q];
    assign ext_doe  = cfg_enable && cs_pin_act && rd_pin_act;

    // interrupt (R7, R10)
    logic wr_evt, rd_evt;
    assign wr_evt = wr_done && (!buffered || wr_ptr_q == LAST_LANE);
    assign rd_evt = rd_done && (!buffered || rd_ptr_q == LAST_LANE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_pulse <= 1'b0;
            irq_flag  <= 1'b0;
        end else begin
            irq_pulse <= cfg_enable && cfg_irq_en && (wr_evt || rd_evt);
            if (irq_pulse)    irq_flag <= 1'b1;
            else if (irq_clr) irq_flag <= 1'b0;
        end
    end

    // R3
    wr_lane_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && cfg_enable) |=> in_full[$past(wr_ptr_q)]);

    // R4
    rd_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && cfg_enable && buffered && rd_ptr_q == LAST_LANE) |=> rd_ptr_q == '0);

    // R10
    irq_flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(irq_pulse));

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(cfg_irq_en) && $past(cfg_enable));

    // R11
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (wr_ptr_q == '0) && (rd_ptr_q == '0) && (in_full == '0) && (&out_empty));

    // R7
    legacy_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !buffered |=> (wr_ptr_q == '0) && (rd_ptr_q == '0));
endmodule

// File: tb/bpsp_port_bench.sv
`timescale 1ns/1ps
module bpsp_port_bench;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n;
    logic        ext_cs, ext_rd, ext_wr;
    logic [7:0]  ext_din;
    logic [7:0]  ext_dout;
    logic        ext_doe;
    logic        cfg_enable;
    logic [1:0]  cfg_mode;
    logic        cfg_cs_pol, cfg_rd_pol, cfg_wr_pol, cfg_irq_en;
    logic        host_in_rd;
    logic [31:0] host_in_word;
    logic [3:0]  in_full;
    logic        host_out_wr;
    logic [31:0] host_out_wdata;
    logic [3:0]  out_empty;
    logic        irq_pulse, irq_flag, irq_clr;

    bpsp_port u_bpsp_port (
        .clk(clk), .rst_n(rst_n),
        .ext_cs(ext_cs), .ext_rd(ext_rd), .ext_wr(ext_wr),
        .ext_din(ext_din), .ext_dout(ext_dout), .ext_doe(ext_doe),
        .cfg_enable(cfg_enable), .cfg_mode(cfg_mode),
        .cfg_cs_pol(cfg_cs_pol), .cfg_rd_pol(cfg_rd_pol), .cfg_wr_pol(cfg_wr_pol),
        .cfg_irq_en(cfg_irq_en),
        .host_in_rd(host_in_rd), .host_in_word(host_in_word), .in_full(in_full),
        .host_out_wr(host_out_wr), .host_out_wdata(host_out_wdata), .out_empty(out_empty),
        .irq_pulse(irq_pulse), .irq_flag(irq_flag), .irq_clr(irq_clr)
    );

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int exp_pulses = 0;
    logic [7:0] model_in [4];
    int model_wptr = 0;

    always @(negedge clk) if (irq_pulse) pulses++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_word();
        return {model_in[3], model_in[2], model_in[1], model_in[0]};
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pins(input bit cs, input bit rd, input bit wr);
        ext_cs = cfg_cs_pol ? cs : !cs;
        ext_rd = cfg_rd_pol ? rd : !rd;
        ext_wr = cfg_wr_pol ? wr : !wr;
    endtask

    task automatic mwrite(input logic [7:0] b, input bit with_cs);
        ext_din = b;
        pins(with_cs, 1'b0, 1'b0); wait_n(1);
        pins(with_cs, 1'b0, 1'b1); wait_n(4);
        pins(with_cs, 1'b0, 1'b0); wait_n(4);
        pins(1'b0, 1'b0, 1'b0);    wait_n(3);
    endtask

    task automatic mread(output logic [7:0] got, output logic oe);
        pins(1'b1, 1'b0, 1'b0); wait_n(1);
        pins(1'b1, 1'b1, 1'b0); wait_n(4);
        got = ext_dout; oe = ext_doe;
        pins(1'b1, 1'b0, 1'b0); wait_n(4);
        pins(1'b0, 1'b0, 1'b0); wait_n(3);
    endtask

    task automatic model_write(input logic [7:0] b, input bit buffered);
        if (buffered) begin
            model_in[model_wptr] = b;
            if (model_wptr == 3) exp_pulses++;
            model_wptr = (model_wptr + 1) % 4;
        end else begin
            model_in[0] = b;
            exp_pulses++;
        end
    endtask

    task automatic host_read_in();
        host_in_rd = 1'b1; wait_n(1); host_in_rd = 1'b0; wait_n(1);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] got;
        logic       oe;
        logic [7:0] b;
        int unsigned seed_v;
        seed_v = $urandom(32'h5EED_0042);
        for (int i = 0; i < 4; i++) model_in[i] = 8'h00;
        rst_n = 1'b0;
        cfg_enable = 1'b0; cfg_mode = 2'b11; cfg_irq_en = 1'b1;
        cfg_cs_pol = 1'b0; cfg_rd_pol = 1'b0; cfg_wr_pol = 1'b0;
        host_in_rd = 1'b0; host_out_wr = 1'b0; host_out_wdata = '0; irq_clr = 1'b0;
        ext_din = '0;
        pins(1'b0, 1'b0, 1'b0);
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);

        // R1 reset state
        check("R1 in_full", {28'd0, in_full}, 32'h0);
        check("R1 out_empty", {28'd0, out_empty}, 32'hF);
        check("R1 irq/oe", {30'd0, irq_flag, ext_doe}, 32'h0);

        cfg_enable = 1'b1;
        wait_n(2);
        host_out_wdata = 32'hDDCCBBAA; host_out_wr = 1'b1; wait_n(1); host_out_wr = 1'b0; wait_n(1);
        check("R9 out_empty cleared", {28'd0, out_empty}, 32'h0);

        // R3 random buffered writes
        for (int i = 0; i < 8; i++) begin
            b = 8'($urandom);
            mwrite(b, 1'b1);
            model_write(b, 1'b1);
            if (i == 0) check("R3 lane0 first", {28'd0, in_full}, 32'h1);
            if (i == 3 || i == 7) begin
                check("R3 word", host_in_word, model_word());
                check("R8 full set", {28'd0, in_full}, 32'hF);
            end
        end
        check("R10 write wrap pulses", pulses, exp_pulses);
        host_read_in();
        check("R8 host read clears", {28'd0, in_full}, 32'h0);

        // R4 reads in lane order, R6 oe while reading
        for (int i = 0; i < 4; i++) begin
            mread(got, oe);
            check("R4 read byte", {24'd0, got}, {24'd0, 8'hAA + 8'(i * 8'h11)});
            check("R6 oe during read", {31'd0, oe}, 32'h1);
        end
        exp_pulses++;
        check("R9 empty after reads", {28'd0, out_empty}, 32'hF);
        check("R10 read wrap pulse", pulses, exp_pulses);
        check("R10 flag sticky", {31'd0, irq_flag}, 32'h1);
        irq_clr = 1'b1; wait_n(1); irq_clr = 1'b0; wait_n(1);
        check("R10 flag cleared", {31'd0, irq_flag}, 32'h0);

        // R6 oe off with only one of cs/rd
        pins(1'b1, 1'b0, 1'b0); wait_n(2);
        check("R6 cs only", {31'd0, ext_doe}, 32'h0);
        pins(1'b0, 1'b1, 1'b0); wait_n(2);
        check("R6 rd only", {31'd0, ext_doe}, 32'h0);
        pins(1'b0, 1'b0, 1'b0); wait_n(3);

        // R5 strobe without chip select is ignored
        mwrite(8'h5A, 1'b0);
        check("R5 ignored write status", {28'd0, in_full}, 32'h0);
        mwrite(8'h11, 1'b1); model_write(8'h11, 1'b1);
        check("R5 next write lane0", {28'd0, in_full}, 32'h1);
        check("R5 word", host_in_word, model_word());

        // R2 active-high polarities
        cfg_cs_pol = 1'b1; cfg_rd_pol = 1'b1; cfg_wr_pol = 1'b1;
        pins(1'b0, 1'b0, 1'b0); wait_n(4);
        for (int i = 0; i < 3; i++) begin
            b = 8'($urandom);
            mwrite(b, 1'b1); model_write(b, 1'b1);
        end
        check("R2 active-high word", host_in_word, model_word());
        check("R2 pulses", pulses, exp_pulses);
        cfg_cs_pol = 1'b0; cfg_rd_pol = 1'b0; cfg_wr_pol = 1'b0;
        pins(1'b0, 1'b0, 1'b0); wait_n(4);

        // R11 disable resets pointers and status
        mwrite(8'h66, 1'b1); model_write(8'h66, 1'b1);
        cfg_enable = 1'b0; wait_n(2);
        check("R11 status cleared", {24'd0, in_full, out_empty}, 32'h0F);
        cfg_enable = 1'b1; wait_n(2);
        model_wptr = 0;
        mwrite(8'h77, 1'b1); model_write(8'h77, 1'b1);
        check("R11 write back at lane0", {28'd0, in_full}, 32'h1);
        check("R11 word", host_in_word, model_word());

        // R7 single-byte mode
        cfg_mode = 2'b00; wait_n(2);
        host_out_wdata = 32'h44332211; host_out_wr = 1'b1; wait_n(1); host_out_wr = 1'b0; wait_n(1);
        host_read_in();
        mwrite(8'h21, 1'b1); model_write(8'h21, 1'b0);
        mwrite(8'h22, 1'b1); model_write(8'h22, 1'b0);
        check("R7 lane0 only", {28'd0, in_full}, 32'h1);
        check("R7 word", host_in_word, model_word());
        for (int i = 0; i < 2; i++) begin
            mread(got, oe);
            exp_pulses++;
            check("R7 read lane0", {24'd0, got}, 32'h11);
        end
        check("R7 pulses per transfer", pulses, exp_pulses);

        // R8 collision: write completes in the cycle of a local read
        cfg_mode = 2'b11; wait_n(2);
        model_wptr = 0;
        host_read_in();
        ext_din = 8'h9C;
        pins(1'b1, 1'b0, 1'b0); wait_n(1);
        pins(1'b1, 1'b0, 1'b1); wait_n(4);
        pins(1'b1, 1'b0, 1'b0); wait_n(2);
        host_in_rd = 1'b1; wait_n(1); host_in_rd = 1'b0;
        model_write(8'h9C, 1'b1);
        wait_n(2);
        pins(1'b0, 1'b0, 1'b0); wait_n(3);
        check("R8 collision set wins", {28'd0, in_full}, 32'h1);
        check("R8 collision byte", {24'd0, host_in_word[7:0]}, 32'h9C);

        // R10 interrupt enable gating
        cfg_irq_en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            b = 8'($urandom);
            mwrite(b, 1'b1);
            model_write(b, 1'b1);
        end
        exp_pulses--;
        check("R10 no pulse when disabled", pulses, exp_pulses);
        check("R3 wrapped word", host_in_word, model_word());

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule